// File: doc/BRIEF.md
# Software Flow-Controlled Serial Byte Buffer

This block sits between a byte-wide UART core and a host that reads and writes whole bytes. Bytes that arrive from the line are queued in a 32-entry circular receive ring until the host reads them. Bytes the host writes are queued in a 128-entry circular transmit ring and are offered to the serializer one at a time. Both sides are plain valid/ready byte ports. The serializer and deserializer themselves are outside the block.

In software mode, the block handles flow control in both directions on its own. Two control bytes from the line are removed from the data stream: 0x13 stops outbound data and 0x11 lets it run again. When the receive ring fills past a high mark, the block sends 0x13 to the peer. When the host drains the ring to a low mark, it sends 0x11. Either control byte goes out ahead of anything queued, even while outbound data is stopped.

In hardware-handshake mode, no control bytes are filtered or sent. Instead, a clear-to-send output follows the receive occupancy with hysteresis, and a request-to-send input from the peer gates outbound data. A flush input empties the receive ring in one cycle and leaves the flow state alone.

Top module: `sw_flow_buffer`

## Requirements
- R1: Data bytes from the line (`urx_valid` high) are queued and delivered on `hr_data`/`hr_valid` in arrival order. A byte leaves the queue on each cycle with `hr_valid` and `hr_ready` both high.
- R2: With `hs_mode` low, a received 0x13 clears the outbound enable and a received 0x11 sets it. Neither byte is queued. When 0x11 arrives while outbound data is waiting, the data is offered again without any new host write.
- R3: With `hs_mode` low, a data byte that arrives while receive occupancy is 16 or more and reception is marked on does two things: it marks reception off and makes 0x13 pending.
- R4: With `hs_mode` low, a host read that leaves occupancy at 8 or less while reception is marked off does two things: it marks reception on and makes 0x11 pending. Occupancies between the two marks send nothing.
- R5: A pending control byte is offered on `utx_data` before any queued host byte, even while outbound data is stopped. It is cleared when `utx_ready` accepts it.
- R6: Host bytes are offered in write order, and only while the outbound enable is set. With nothing queued, or with flow stopped and nothing pending, `utx_valid` is low.
- R7: A data byte that arrives while the receive ring holds 32 bytes is dropped.
- R8: With `hs_mode` high, `cts_ok` falls once occupancy reaches 31 and rises again once it falls to 8 or less. Host bytes are offered only while `peer_rts` is high. 0x11 and 0x13 are queued as ordinary data, and no control byte is ever sent.
- R9: The transmit ring holds 128 bytes. `hw_ready` is low when it is full, a write is taken when `hw_valid` and `hw_ready` are both high, and indexing wraps around.
- R10: A one-cycle `flush` pulse empties the receive ring. It does not change the reception-on mark or the pending control byte.
- R11: After reset, both rings are empty, reception and outbound data are enabled, no control byte is pending, and `cts_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 selects hardware handshake, 0 selects control-byte flow |
| flush | input | 1 | Empties the receive ring |
| urx_valid | input | 1 | A byte from the deserializer is present |
| urx_data | input | 8 | Byte from the deserializer |
| utx_valid | output | 1 | A byte is offered to the serializer |
| utx_data | output | 8 | Byte offered to the serializer |
| utx_ready | input | 1 | Serializer takes the offered byte |
| hw_valid | input | 1 | Host write strobe |
| hw_data | input | 8 | Host write byte |
| hw_ready | output | 1 | Transmit ring has room |
| hr_valid | output | 1 | Receive ring is not empty |
| hr_data | output | 8 | Oldest received byte |
| hr_ready | input | 1 | Host takes the oldest received byte |
| peer_rts | input | 1 | Peer request-to-send, high = data may be sent |
| cts_ok | output | 1 | Clear-to-send to the peer, high = peer may send |

## Verification
The hardest case to reach is the one where every flow rule acts on the same buffer at once. Outbound data must be stopped by a received 0x13 while a host byte waits in the transmit ring. The receive ring is then driven past the high mark and on to full, so the injected 0x13 overtakes the waiting byte, and the overflow bytes are dropped. The host then drains the ring one read at a time. The bench checks that nothing is sent while occupancy is between the marks, and that 0x11 appears exactly on the read that reaches 8. Only after a later line 0x11 may the waiting host byte finally leave.

// File: rtl/flowbuf_pkg.sv
package flowbuf_pkg;

  localparam logic [7:0] CH_RESUME = 8'h11;
  localparam logic [7:0] CH_PAUSE  = 8'h13;

  // Occupancy at or above which reception is paused.
  function automatic int unsigned upper_mark(input int unsigned depth);
    return depth / 2;
  endfunction

  // Occupancy at or below which reception resumes.
  function automatic int unsigned lower_mark(input int unsigned depth);
    return depth / 4;
  endfunction

  // Occupancy at which the hardware clear-to-send drops.
  function automatic int unsigned cts_drop_mark(input int unsigned depth);
    return depth - 1;
  endfunction

  function automatic logic is_flow_byte(input logic [7:0] b);
    return (b == CH_RESUME) || (b == CH_PAUSE);
  endfunction

endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_idx, wr_idx;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH)) && !flush;
  assign do_pop  = pop && (count != '0) && !flush;
  assign dout    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_idx <= wr_idx + 1'b1;
      if (do_pop)  rd_idx <= rd_idx + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= din;
  end

endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
  import flowbuf_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 32,
  localparam int unsigned CW      = $clog2(RX_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_mode,
  input  logic          flush,
  input  logic          urx_valid,
  input  logic [7:0]    urx_data,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_pop,
  input  logic          flow_taken,
  output logic          rx_push,
  output logic          tx_en,
  output logic          rx_on,
  output logic          pend_valid,
  output logic [7:0]    pend_char,
  output logic          cts_q,
  output logic          evt_pause,
  output logic          evt_resume,
  output logic          evt_ctl
);

  localparam logic [CW-1:0] HI_M  = CW'(upper_mark(RX_DEPTH));
  localparam logic [CW-1:0] LO_M  = CW'(lower_mark(RX_DEPTH));
  localparam logic [CW-1:0] CTS_M = CW'(cts_drop_mark(RX_DEPTH));
  localparam logic [CW-1:0] FULL  = CW'(RX_DEPTH);

  logic          data_in;
  logic [CW-1:0] after_read;
  logic [CW-1:0] cnt_next;

  assign evt_ctl    = !hs_mode && urx_valid && is_flow_byte(urx_data);
  assign data_in    = urx_valid && !evt_ctl;
  assign rx_push    = data_in && (rx_count != FULL) && !flush;
  assign after_read = rx_count - 1'b1;
  assign evt_pause  = !hs_mode && data_in && rx_on && (rx_count >= HI_M);
  assign evt_resume = !hs_mode && rx_pop && !rx_on && (after_read <= LO_M);

  always_comb begin
    if (flush) cnt_next = '0;
    else       cnt_next = rx_count + CW'(rx_push) - CW'(rx_pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en      <= 1'b1;
      rx_on      <= 1'b1;
      pend_valid <= 1'b0;
      pend_char  <= 8'h00;
      cts_q      <= 1'b1;
    end else begin
      if (evt_ctl) tx_en <= (urx_data == CH_RESUME);

      if (evt_pause) begin
        rx_on      <= 1'b0;
        pend_valid <= 1'b1;
        pend_char  <= CH_PAUSE;
      end else if (evt_resume) begin
        rx_on      <= 1'b1;
        pend_valid <= 1'b1;
        pend_char  <= CH_RESUME;
      end else if (flow_taken) begin
        pend_valid <= 1'b0;
      end

      if (cnt_next >= CTS_M)     cts_q <= 1'b0;
      else if (cnt_next <= LO_M) cts_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_arbiter.sv
module tx_arbiter (
  input  logic       hs_mode,
  input  logic       pend_valid,
  input  logic [7:0] pend_char,
  input  logic       tx_en,
  input  logic       peer_rts,
  input  logic       tx_nonempty,
  input  logic [7:0] tx_head,
  input  logic       utx_ready,
  output logic       utx_valid,
  output logic [7:0] utx_data,
  output logic       flow_taken,
  output logic       tx_pop
);

  logic data_ok, pick_flow, pick_data;

  assign data_ok   = hs_mode ? peer_rts : tx_en;
  assign pick_flow = !hs_mode && pend_valid;
  assign pick_data = !pick_flow && tx_nonempty && data_ok;

  assign utx_valid  = pick_flow || pick_data;
  assign utx_data   = pick_flow ? pend_char : (pick_data ? tx_head : 8'h00);
  assign flow_taken = pick_flow && utx_ready;
  assign tx_pop     = pick_data && utx_ready;

endmodule

// File: rtl/sw_flow_buffer.sv
module sw_flow_buffer #(
  parameter int unsigned RX_DEPTH = 32,
  parameter int unsigned TX_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_mode,
  input  logic       flush,
  input  logic       urx_valid,
  input  logic [7:0] urx_data,
  output logic       utx_valid,
  output logic [7:0] utx_data,
  input  logic       utx_ready,
  input  logic       hw_valid,
  input  logic [7:0] hw_data,
  output logic       hw_ready,
  output logic       hr_valid,
  output logic [7:0] hr_data,
  input  logic       hr_ready,
  input  logic       peer_rts,
  output logic       cts_ok
);

  localparam int unsigned RX_CW = $clog2(RX_DEPTH) + 1;
  localparam int unsigned TX_CW = $clog2(TX_DEPTH) + 1;

  logic [RX_CW-1:0] rx_count;
  logic [TX_CW-1:0] tx_count;
  logic [7:0]       tx_head;
  logic             rx_push, rx_pop, tx_push, tx_pop;
  logic             tx_en, rx_on, pend_valid, cts_q, flow_taken;
  logic [7:0]       pend_char;
  logic             evt_pause, evt_resume, evt_ctl;

  assign hr_valid = (rx_count != '0);
  assign rx_pop   = hr_valid && hr_ready && !flush;
  assign hw_ready = (tx_count != TX_CW'(TX_DEPTH));
  assign tx_push  = hw_valid && hw_ready;
  assign cts_ok   = hs_mode ? cts_q : 1'b1;

  byte_ring #(.DEPTH(RX_DEPTH), .W(8)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .din(urx_data),
    .pop(rx_pop), .dout(hr_data), .count(rx_count)
  );

  byte_ring #(.DEPTH(TX_DEPTH), .W(8)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .push(tx_push), .din(hw_data),
    .pop(tx_pop), .dout(tx_head), .count(tx_count)
  );

  rx_flow_ctl #(.RX_DEPTH(RX_DEPTH)) u_flow (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .flush(flush),
    .urx_valid(urx_valid), .urx_data(urx_data),
    .rx_count(rx_count), .rx_pop(rx_pop), .flow_taken(flow_taken),
    .rx_push(rx_push), .tx_en(tx_en), .rx_on(rx_on),
    .pend_valid(pend_valid), .pend_char(pend_char), .cts_q(cts_q),
    .evt_pause(evt_pause), .evt_resume(evt_resume), .evt_ctl(evt_ctl)
  );

  tx_arbiter u_arb (
    .hs_mode(hs_mode), .pend_valid(pend_valid), .pend_char(pend_char),
    .tx_en(tx_en), .peer_rts(peer_rts),
    .tx_nonempty(tx_count != '0), .tx_head(tx_head),
    .utx_ready(utx_ready), .utx_valid(utx_valid), .utx_data(utx_data),
    .flow_taken(flow_taken), .tx_pop(tx_pop)
  );

endmodule

// File: rtl/flowbuf_checker.sv
module flowbuf_checker #(
  parameter int unsigned RX_DEPTH = 32,
  parameter int unsigned TX_DEPTH = 128,
  localparam int unsigned RX_CW   = $clog2(RX_DEPTH) + 1,
  localparam int unsigned TX_CW   = $clog2(TX_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_mode,
  input logic             peer_rts,
  input logic             flush,
  input logic             utx_valid,
  input logic [7:0]       utx_data,
  input logic             hw_ready,
  input logic             cts_ok,
  input logic [RX_CW-1:0] rx_count,
  input logic [TX_CW-1:0] tx_count,
  input logic             rx_pop,
  input logic             tx_en,
  input logic             rx_on,
  input logic             pend_valid,
  input logic [7:0]       pend_char,
  input logic             evt_pause,
  input logic             evt_resume,
  input logic             evt_ctl
);

  // R7
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RX_CW'(RX_DEPTH));

  // R2
  ctl_not_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ctl && !rx_pop && !flush |=> rx_count == $past(rx_count));

  // R3
  pause_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pause |=> pend_valid && pend_char == 8'h13 && !rx_on);

  // R4
  resume_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume |=> pend_valid && pend_char == 8'h11 && rx_on);

  // R5
  flow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode && pend_valid |-> utx_valid && utx_data == pend_char);

  // R6
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode && !tx_en && !pend_valid |-> !utx_valid);

  // R8
  rts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode && !peer_rts |-> !utx_valid);

  // R8
  cts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode && rx_count >= RX_CW'(RX_DEPTH - 1) |-> !cts_ok);

  // R9
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count == TX_CW'(TX_DEPTH) |-> !hw_ready);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rx_count == '0 && rx_on == $past(rx_on));

endmodule

bind sw_flow_buffer flowbuf_checker #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .peer_rts(peer_rts),
  .flush(flush), .utx_valid(utx_valid), .utx_data(utx_data),
  .hw_ready(hw_ready), .cts_ok(cts_ok), .rx_count(rx_count),
  .tx_count(tx_count), .rx_pop(rx_pop), .tx_en(tx_en), .rx_on(rx_on),
  .pend_valid(pend_valid), .pend_char(pend_char),
  .evt_pause(evt_pause), .evt_resume(evt_resume), .evt_ctl(evt_ctl)
);

// File: tb/sw_flow_buffer_tb.sv
module sw_flow_buffer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_mode = 1'b0;
  logic       flush = 1'b0;
  logic       urx_valid = 1'b0;
  logic [7:0] urx_data = 8'h00;
  logic       utx_valid;
  logic [7:0] utx_data;
  logic       utx_ready = 1'b0;
  logic       hw_valid = 1'b0;
  logic [7:0] hw_data = 8'h00;
  logic       hw_ready;
  logic       hr_valid;
  logic [7:0] hr_data;
  logic       hr_ready = 1'b0;
  logic       peer_rts = 1'b1;
  logic       cts_ok;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sw_flow_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .flush(flush),
    .urx_valid(urx_valid), .urx_data(urx_data),
    .utx_valid(utx_valid), .utx_data(utx_data), .utx_ready(utx_ready),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
    .hr_valid(hr_valid), .hr_data(hr_data), .hr_ready(hr_ready),
    .peer_rts(peer_rts), .cts_ok(cts_ok)
  );

  localparam logic [2:0] OP_RX = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_TK = 3'd3, OP_NR = 3'd4, OP_IDL = 3'd5;
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    {OP_RX, 8'h41}, {OP_RD, 8'h41}, {OP_RX, 8'h13}, {OP_RX, 8'h42},
    {OP_RD, 8'h42}, {OP_NR, 8'h00}, {OP_WR, 8'h55}, {OP_IDL, 8'h00},
    {OP_RX, 8'h11}, {OP_TK, 8'h55}, {OP_WR, 8'hA0}, {OP_WR, 8'hA1},
    {OP_TK, 8'hA0}, {OP_TK, 8'hA1}, {OP_IDL, 8'h00}, {OP_RX, 8'h7E},
    {OP_RX, 8'h00}, {OP_RD, 8'h7E}, {OP_RD, 8'h00}, {OP_NR, 8'h00}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic hs);
    @(negedge clk);
    rst_n = 1'b0; hs_mode = hs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d);
    urx_valid = 1'b1; urx_data = d;
    @(negedge clk);
    urx_valid = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    hw_valid = 1'b1; hw_data = d;
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] exp, input string tag);
    chk(hr_valid, 1, tag);
    chk(hr_data, exp, tag);
    hr_ready = 1'b1;
    @(negedge clk);
    hr_ready = 1'b0;
  endtask

  task automatic uart_take(input logic [7:0] exp, input string tag);
    chk(utx_valid, 1, tag);
    chk(utx_data, exp, tag);
    utx_ready = 1'b1;
    @(negedge clk);
    utx_ready = 1'b0;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=expired expected=done");
    report();
  end

  initial begin
    // R11 reset state
    do_reset(1'b0);
    chk(hr_valid, 0, "R11 rx empty");
    chk(utx_valid, 0, "R11 nothing offered");
    chk(hw_ready, 1, "R11 tx room");
    chk(cts_ok, 1, "R11 cts");

    // Vector walk: R1 data order, R2 control bytes, R6 send order and idle
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][10:8])
        OP_RX:  rx_send(VEC[i][7:0]);
        OP_WR:  host_write(VEC[i][7:0]);
        OP_RD:  host_read(VEC[i][7:0], "R1 read order");
        OP_TK:  uart_take(VEC[i][7:0], "R6 send order");
        OP_NR:  chk(hr_valid, 0, "R2 control byte not queued");
        default: chk(utx_valid, 0, "R6 idle");
      endcase
    end

    // R3 / R5 / R7 / R4: pause, overflow, hysteresis, resume
    do_reset(1'b0);
    rx_send(8'h13);
    host_write(8'h66);
    chk(utx_valid, 0, "R2 data halted");
    for (int i = 0; i < 16; i++) rx_send(8'h80 + 8'(i));
    chk(utx_valid, 0, "R3 no pause below mark");
    rx_send(8'h90);
    uart_take(8'h13, "R5 pause byte first while halted");
    chk(utx_valid, 0, "R6 data still held");
    for (int i = 17; i < 32; i++) rx_send(8'h80 + 8'(i));
    rx_send(8'hEE);
    rx_send(8'hEF);
    chk(utx_valid, 0, "R3 single pause");
    for (int i = 0; i < 23; i++) host_read(8'h80 + 8'(i), "R7 kept bytes");
    chk(utx_valid, 0, "R4 hysteresis");
    host_read(8'h97, "R7 kept bytes");
    uart_take(8'h11, "R4 resume at low mark");
    chk(utx_valid, 0, "R2 still halted");
    for (int i = 24; i < 32; i++) host_read(8'h80 + 8'(i), "R7 kept bytes");
    chk(hr_valid, 0, "R7 overflow dropped");
    rx_send(8'h11);
    uart_take(8'h66, "R2 restart on resume");

    // R10 flush keeps flow state
    for (int i = 0; i < 17; i++) rx_send(8'h40 + 8'(i));
    uart_take(8'h13, "R3 pause at mark");
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(hr_valid, 0, "R10 flush empties");
    chk(utx_valid, 0, "R10 no resume from flush");
    rx_send(8'h5A);
    host_read(8'h5A, "R10 after flush");
    uart_take(8'h11, "R10 flow state kept");

    // R9 transmit ring depth and wrap
    do_reset(1'b0);
    for (int i = 0; i < 128; i++) host_write(8'(i) ^ 8'hC3);
    chk(hw_ready, 0, "R9 full");
    host_write(8'hAB);
    for (int i = 0; i < 128; i++) uart_take(8'(i) ^ 8'hC3, "R9 order");
    chk(utx_valid, 0, "R9 extra write dropped");
    host_write(8'h5C);
    uart_take(8'h5C, "R9 wrap");

    // R8 hardware handshake
    do_reset(1'b1);
    chk(cts_ok, 1, "R8 cts after reset");
    rx_send(8'h13);
    for (int i = 1; i < 30; i++) rx_send(8'h20 + 8'(i));
    chk(cts_ok, 1, "R8 cts at 30");
    chk(utx_valid, 0, "R8 no control byte sent");
    rx_send(8'h3E);
    chk(cts_ok, 0, "R8 cts drop at 31");
    host_read(8'h13, "R8 control byte queued");
    for (int i = 1; i < 22; i++) host_read(8'h20 + 8'(i), "R8 read");
    chk(cts_ok, 0, "R8 cts hysteresis");
    host_read(8'h36, "R8 read");
    chk(cts_ok, 1, "R8 cts rise at 8");
    peer_rts = 1'b0;
    host_write(8'h77);
    chk(utx_valid, 0, "R8 rts low holds data");
    peer_rts = 1'b1;
    @(negedge clk);
    uart_take(8'h77, "R8 rts high sends");

    report();
  end

endmodule